// File: doc/BRIEF.md
# Dual-Register Programmable Logic Macrocell

This block is one configurable cell of a sum-of-products programmable logic array. A vector of global signals comes in, and each signal is expanded into a true and a complement literal. A configuration word gives every product-term AND gate one connect bit per literal. Seventeen product terms are evaluated. The five lowest act as control terms: two asynchronous clears, two clocks and an output enable. The remaining twelve are ORed in groups of four into three sum terms.

Two registers sit behind the sum terms. Each register can be set to latch its data (D mode) or to invert when its data is 1 (T mode). Each register takes its clock from either its own product-term clock or a dedicated clock input. Both share one synchronous preset line with neighbouring cells. All register state runs on the system clock `clk`. A rising edge of the selected clock source is detected by comparing its value with the value it had one system cycle earlier.

The cell drives a pin through an output enable. The pin carries either register 1 or the combinatorial sum term 2. The cell also returns six feedback literals to the global bus.

Top module: `dual_reg_macrocell`

## Requirements
- R1: Literal 2i is bus signal i and literal 2i+1 is its complement. Connect bit p*172+l selects literal l for product term p. A product term is the AND of its selected literals: with no literal selected it is 1, and with a signal and its complement both selected it is 0.
- R2: The control terms are fixed by index: term 0 clears register 1, term 1 clocks register 1, term 2 clocks register 2, term 3 clears register 2, and term 4 enables the pin driver. Clearing register 2 leaves register 1 unchanged.
- R3: Sum term k is the OR of product terms 5+4k through 8+4k. Sum 0 is the data of register 1, sum 1 is the data of register 2, and sum 2 is the combinatorial pin source.
- R4: In D mode (cfg_toggle bit n = 0), a rising edge of the register's selected clock loads the data, and the new value is seen one system cycle after the edge is sampled. With no rising edge, the register holds its value even while its clock stays high.
- R5: In T mode (cfg_toggle bit n = 1), a rising edge inverts the register when the data is 1 and keeps it when the data is 0.
- R6: When cfg_clk_pin bit n is 1, register n is clocked by in_clk. When it is 0, register n is clocked by its product-term clock. Edges on the source that is not selected have no effect.
- R7: While its clear term is 1, a register reads 0 in the same cycle. Clock edges during the clear are ignored, and the register stays 0 after the clear ends.
- R8: A clock edge with preset at 1 sets the register to 1 whatever its data. A clear active at the same time wins, and the register stays 0.
- R9: pin_oe equals product term 4. When pin_oe is 0, the pin literals follow pin_in. When it is 1, they follow pin_out.
- R10: With cfg_pin_reg at 1, pin_out is register 1. With it at 0, pin_out is sum term 2.
- R11: With cfg_fb_reg at 1, the second feedback is register 2. With it at 0, the second feedback is sum term 1, which is register 2's data input.
- R12: fb_lits bits 0 to 5 carry, in order: feedback, its complement, register 1, its complement, the pin literal, and its complement.
- R13: While rst_n is low, both registers are 0 and every edge detector holds a past value of 1. As a result, no edge is seen after reset until the selected source has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers update on its rising edge |
| rst_n | input | 1 | Active-low power-on clear |
| in_clk | input | 1 | Dedicated clock input, selectable per register |
| preset | input | 1 | Shared synchronous preset line |
| bus_sig | input | NUM_SIG | Global bus signals |
| cfg_conn | input | 17*2*NUM_SIG | Connect bits, NUM_LITS per product term |
| cfg_toggle | input | 2 | Per register: 1 selects T mode, 0 selects D mode |
| cfg_clk_pin | input | 2 | Per register: 1 selects in_clk, 0 selects the product-term clock |
| cfg_fb_reg | input | 1 | Feedback source: 1 selects register 2, 0 selects sum term 1 |
| cfg_pin_reg | input | 1 | Pin source: 1 selects register 1, 0 selects sum term 2 |
| pin_in | input | 1 | Value driven onto the pin from outside |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable; 0 means high impedance |
| fb_lits | output | 6 | Feedback literals returned to the global bus |

## Verification
Product terms, sum terms, pin_oe, pin_out from sum term 2, the feedback taken from sum term 1, and the clear forcing are combinatorial. These results are due in the same cycle that the stimulus is applied. A register load, toggle or preset is due one system cycle later, because the edge is sampled at the next `clk` rising edge. The driver records each expected value with its due cycle, 0 or 1 cycles after the stimulus. The monitor compares only at the falling edge of the due cycle, so values in transit are never sampled.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int NUM_PT     = 17;
  localparam int NUM_CTRL   = 5;
  localparam int PT_PER_SUM = 4;
  localparam int NUM_SUM    = (NUM_PT - NUM_CTRL) / PT_PER_SUM;
  localparam int NUM_FF     = 2;
  localparam int FB_W       = 6;

  // Control-term indices; the order is fixed by the cell's behaviour.
  localparam int PT_CLR1 = 0;
  localparam int PT_CLK1 = 1;
  localparam int PT_CLK2 = 2;
  localparam int PT_CLR2 = 3;
  localparam int PT_OE   = 4;

  // Next register value on a detected clock edge.
  function automatic logic ff_next(input logic q, input logic d,
                                   input logic toggle, input logic pre);
    if (pre)         return 1'b1;
    else if (toggle) return q ^ d;
    else             return d;
  endfunction

  // True / complement pair of one literal.
  function automatic logic [1:0] lit_pair(input logic x);
    return {~x, x};
  endfunction
endpackage

// File: rtl/mc_pterm_array.sv
module mc_pterm_array #(
  parameter int NUM_SIG = 86
) (
  input  logic [NUM_SIG-1:0]                    bus_sig,
  input  logic [mc_pkg::NUM_PT*2*NUM_SIG-1:0]   cfg_conn,
  output logic [mc_pkg::NUM_PT-1:0]             pt_out
);
  localparam int NUM_LITS = 2 * NUM_SIG;

  logic [NUM_LITS-1:0] lits;

  // AND of every literal whose connect bit is set.
  function automatic logic pt_and(input logic [NUM_LITS-1:0] l,
                                  input logic [NUM_LITS-1:0] m);
    return &(l | ~m);
  endfunction

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_lit
    assign lits[2*i]   = bus_sig[i];
    assign lits[2*i+1] = ~bus_sig[i];
  end

  for (genvar p = 0; p < mc_pkg::NUM_PT; p++) begin : g_pt
    assign pt_out[p] = pt_and(lits, cfg_conn[p*NUM_LITS +: NUM_LITS]);
  end
endmodule

// File: rtl/mc_sum_array.sv
module mc_sum_array (
  input  logic [mc_pkg::NUM_SUM*mc_pkg::PT_PER_SUM-1:0] terms,
  output logic [mc_pkg::NUM_SUM-1:0]                    sums
);
  localparam int W = mc_pkg::PT_PER_SUM;

  for (genvar k = 0; k < mc_pkg::NUM_SUM; k++) begin : g_sum
    assign sums[k] = |terms[k*W +: W];
  end
endmodule

// File: rtl/mc_flop.sv
module mc_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_src,
  input  logic clr,
  input  logic pre,
  input  logic d,
  input  logic toggle,
  output logic q,
  output logic edge_seen
);
  logic prev_src;
  logic q_reg;

  assign edge_seen = clk_src & ~prev_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_src <= 1'b1;
      q_reg    <= 1'b0;
    end else begin
      prev_src <= clk_src;
      if (clr)            q_reg <= 1'b0;
      else if (edge_seen) q_reg <= mc_pkg::ff_next(q_reg, d, toggle, pre);
    end
  end

  // Clear acts without waiting for a clock.
  assign q = clr ? 1'b0 : q_reg;
endmodule

// File: rtl/mc_output.sv
module mc_output (
  input  logic                     oe_pt,
  input  logic                     pin_from_reg,
  input  logic                     fb_from_reg,
  input  logic                     q1,
  input  logic                     q2,
  input  logic                     sum_comb,
  input  logic                     d2,
  input  logic                     pin_in,
  output logic                     pin_out,
  output logic                     pin_oe,
  output logic [mc_pkg::FB_W-1:0]  fb_lits
);
  logic fb2;
  logic pin_lit;

  assign pin_out = pin_from_reg ? q1 : sum_comb;
  assign pin_oe  = oe_pt;
  assign pin_lit = oe_pt ? pin_out : pin_in;
  assign fb2     = fb_from_reg ? q2 : d2;
  assign fb_lits = {mc_pkg::lit_pair(pin_lit), mc_pkg::lit_pair(q1),
                    mc_pkg::lit_pair(fb2)};
endmodule

// File: rtl/dual_reg_macrocell.sv
module dual_reg_macrocell #(
  parameter int NUM_SIG = 86
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_clk,
  input  logic                                  preset,
  input  logic [NUM_SIG-1:0]                    bus_sig,
  input  logic [mc_pkg::NUM_PT*2*NUM_SIG-1:0]   cfg_conn,
  input  logic [1:0]                            cfg_toggle,
  input  logic [1:0]                            cfg_clk_pin,
  input  logic                                  cfg_fb_reg,
  input  logic                                  cfg_pin_reg,
  input  logic                                  pin_in,
  output logic                                  pin_out,
  output logic                                  pin_oe,
  output logic [5:0]                            fb_lits
);
  import mc_pkg::*;

  logic [NUM_PT-1:0]  pt;
  logic [NUM_SUM-1:0] sum;

  // Named per-register events, brought out for the checker.
  logic [NUM_FF-1:0] ff_clk_pt;
  logic [NUM_FF-1:0] ff_clk_src;
  logic [NUM_FF-1:0] ff_ar;
  logic [NUM_FF-1:0] ff_d;
  logic [NUM_FF-1:0] ff_q;
  logic [NUM_FF-1:0] ff_edge;

  mc_pterm_array #(.NUM_SIG(NUM_SIG)) u_pt (
    .bus_sig (bus_sig),
    .cfg_conn(cfg_conn),
    .pt_out  (pt)
  );

  mc_sum_array u_sum (
    .terms(pt[NUM_PT-1:NUM_CTRL]),
    .sums (sum)
  );

  assign ff_clk_pt = {pt[PT_CLK2], pt[PT_CLK1]};
  assign ff_ar     = {pt[PT_CLR2], pt[PT_CLR1]};
  assign ff_d      = sum[NUM_FF-1:0];

  for (genvar n = 0; n < NUM_FF; n++) begin : g_ff
    assign ff_clk_src[n] = cfg_clk_pin[n] ? in_clk : ff_clk_pt[n];

    mc_flop u_ff (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_src  (ff_clk_src[n]),
      .clr      (ff_ar[n]),
      .pre      (preset),
      .d        (ff_d[n]),
      .toggle   (cfg_toggle[n]),
      .q        (ff_q[n]),
      .edge_seen(ff_edge[n])
    );
  end

  mc_output u_out (
    .oe_pt       (pt[PT_OE]),
    .pin_from_reg(cfg_pin_reg),
    .fb_from_reg (cfg_fb_reg),
    .q1          (ff_q[0]),
    .q2          (ff_q[1]),
    .sum_comb    (sum[NUM_SUM-1]),
    .d2          (ff_d[1]),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .fb_lits     (fb_lits)
  );
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       preset,
  input logic [1:0] cfg_toggle,
  input logic [1:0] ff_edge,
  input logic [1:0] ff_ar,
  input logic [1:0] ff_d,
  input logic [1:0] ff_q
);
  AST_CLR1_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ff_ar[0] |=> !ff_q[0]); // R7

  AST_CLR2_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ff_ar[1] |=> !ff_q[1]); // R7

  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ff_edge[0] && !ff_ar[0]) |=> (ff_ar[0] || $stable(ff_q[0]))); // R4

  AST_D_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_edge[0] && !cfg_toggle[0] && !preset && !ff_ar[0])
      |=> (ff_ar[0] || ff_q[0] == $past(ff_d[0]))); // R4

  AST_T_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_edge[1] && cfg_toggle[1] && !preset && !ff_ar[1])
      |=> (ff_ar[1] || ff_q[1] == ($past(ff_q[1]) ^ $past(ff_d[1])))); // R5

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_edge[0] && preset && !ff_ar[0]) |=> (ff_ar[0] || ff_q[0])); // R8

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ff_edge[0] |=> !ff_edge[0]); // R6
endmodule

bind dual_reg_macrocell mc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .preset    (preset),
  .cfg_toggle(cfg_toggle),
  .ff_edge   (ff_edge),
  .ff_ar     (ff_ar),
  .ff_d      (ff_d),
  .ff_q      (ff_q)
);

// File: tb/sim_dual_reg_macrocell.sv
`timescale 1ns/1ps
module sim_dual_reg_macrocell;
  localparam int NS = 86;
  localparam int NL = 2 * NS;
  localparam int NP = 17;

  localparam int SEL_PINOUT = 0;
  localparam int SEL_OE     = 1;
  localparam int SEL_Q1     = 2;
  localparam int SEL_FB2    = 3;
  localparam int SEL_PINLIT = 4;
  localparam int SEL_FB     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_clk = 1'b0;
  logic preset = 1'b0;
  logic [NS-1:0] sig = '0;
  logic [NP*NL-1:0] cfg_conn = '0;
  logic [1:0] cfg_toggle = 2'b00;
  logic [1:0] cfg_clk_pin = 2'b00;
  logic cfg_fb_reg = 1'b0;
  logic cfg_pin_reg = 1'b0;
  logic pin_in = 1'b0;
  logic pin_out, pin_oe;
  logic [5:0] fb_lits;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int        q_due[$];
  int        q_sel[$];
  logic [7:0] q_exp[$];
  string     q_tag[$];

  dual_reg_macrocell #(.NUM_SIG(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_clk(in_clk), .preset(preset),
    .bus_sig(sig), .cfg_conn(cfg_conn), .cfg_toggle(cfg_toggle),
    .cfg_clk_pin(cfg_clk_pin), .cfg_fb_reg(cfg_fb_reg),
    .cfg_pin_reg(cfg_pin_reg), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb_lits(fb_lits)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] observe(input int sel);
    case (sel)
      SEL_PINOUT: return {7'd0, pin_out};
      SEL_OE:     return {7'd0, pin_oe};
      SEL_Q1:     return {7'd0, fb_lits[2]};
      SEL_FB2:    return {7'd0, fb_lits[0]};
      SEL_PINLIT: return {7'd0, fb_lits[4]};
      default:    return {2'd0, fb_lits};
    endcase
  endfunction

  // Monitor: compares each item in the falling-edge half of its due cycle.
  always @(negedge clk) begin
    for (int i = q_due.size() - 1; i >= 0; i--) begin
      if (q_due[i] == cyc) begin
        logic [7:0] got;
        got = observe(q_sel[i]);
        n_cmp++;
        if (got !== q_exp[i]) begin
          n_bad++;
          $display("FAIL %s: got %0h expected %0h (cycle %0d)",
                   q_tag[i], got, q_exp[i], cyc);
        end
        q_due.delete(i); q_sel.delete(i); q_exp.delete(i); q_tag.delete(i);
      end
    end
  end

  task automatic expect_at(input int lat, input int sel, input logic [7:0] v,
                           input string tag);
    q_due.push_back(cyc + lat);
    q_sel.push_back(sel);
    q_exp.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic conn(input int p, input int s, input bit neg);
    cfg_conn[p*NL + 2*s + int'(neg)] = 1'b1;
  endtask

  task automatic zero_pt(input int p);
    conn(p, 9, 1'b0);
    conn(p, 9, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    tick(); tick();
    // R13 R1: empty terms are 1, clears force both registers to 0
    expect_at(0, SEL_FB, 8'h19, "R13 R1 reset state");
    tick();
    rst_n = 1'b1;
    tick();

    // Signal map: s0 clr1, s1 clk1, s2 clk2, s3 clr2, s4 oe, s5 d1, s6 d2, s7/s8 sum2
    conn(0, 0, 0); conn(1, 1, 0); conn(2, 2, 0); conn(3, 3, 0); conn(4, 4, 0);
    conn(5, 5, 0); zero_pt(6); zero_pt(7); zero_pt(8);
    conn(9, 6, 0); zero_pt(10); zero_pt(11); zero_pt(12);
    conn(13, 7, 0); conn(13, 8, 0); zero_pt(14); zero_pt(15); zero_pt(16);
    pin_in = 1'b1;
    tick();
    expect_at(0, SEL_OE, 0, "R9 driver off");
    expect_at(0, SEL_PINLIT, 1, "R9 pin literal from pin_in");
    tick();
    pin_in = 1'b0;
    expect_at(0, SEL_PINLIT, 0, "R9 pin literal from pin_in");
    tick();
    sig[4] = 1'b1;
    expect_at(0, SEL_OE, 1, "R2 R9 term 4 enables");
    expect_at(0, SEL_PINOUT, 0, "R3 sum2");
    tick();
    sig[7] = 1'b1;
    expect_at(0, SEL_PINOUT, 0, "R1 AND needs all literals");
    tick();
    sig[8] = 1'b1;
    expect_at(0, SEL_PINOUT, 1, "R1 R3 R10 sum2 to pin");
    expect_at(0, SEL_PINLIT, 1, "R9 pin literal from pin_out");
    tick();

    // R4 D mode on register 1
    sig[5] = 1'b1; sig[1] = 1'b1;
    expect_at(0, SEL_Q1, 0, "R4 not yet loaded");
    expect_at(1, SEL_Q1, 1, "R4 load 1");
    tick(); tick();
    sig[5] = 1'b0;
    expect_at(1, SEL_Q1, 1, "R4 hold while clock high");
    tick(); tick();
    sig[1] = 1'b0; tick();
    sig[1] = 1'b1;
    expect_at(1, SEL_Q1, 0, "R4 load 0");
    tick(); tick();

    // R5 T mode on register 2, observed through registered feedback
    cfg_toggle = 2'b10; cfg_fb_reg = 1'b1;
    sig[6] = 1'b1; sig[2] = 1'b1;
    expect_at(0, SEL_FB2, 0, "R11 feedback is Q2");
    expect_at(1, SEL_FB2, 1, "R5 toggle up");
    tick(); tick();
    sig[2] = 1'b0; tick();
    sig[2] = 1'b1;
    expect_at(1, SEL_FB2, 0, "R5 toggle down");
    tick(); tick();
    sig[2] = 1'b0; sig[6] = 1'b0; tick();
    sig[2] = 1'b1;
    expect_at(1, SEL_FB2, 0, "R5 hold with data 0");
    tick(); tick();
    sig[2] = 1'b0; tick();

    // R6 register 1 moved to the dedicated clock
    cfg_clk_pin = 2'b01; tick();
    sig[1] = 1'b0; tick();
    sig[5] = 1'b1; sig[1] = 1'b1;
    expect_at(1, SEL_Q1, 0, "R6 term clock ignored");
    tick(); tick();
    in_clk = 1'b1;
    expect_at(1, SEL_Q1, 1, "R6 in_clk loads");
    tick(); tick();
    in_clk = 1'b0; tick();

    // R7 asynchronous clear
    sig[0] = 1'b1;
    expect_at(0, SEL_Q1, 0, "R7 immediate clear");
    tick();
    in_clk = 1'b1;
    expect_at(1, SEL_Q1, 0, "R7 edge ignored");
    tick(); tick();
    in_clk = 1'b0; tick();
    sig[0] = 1'b0;
    expect_at(0, SEL_Q1, 0, "R7 stays 0 after clear");
    tick();

    // R8 synchronous preset
    sig[5] = 1'b0; preset = 1'b1; in_clk = 1'b1;
    expect_at(1, SEL_Q1, 1, "R8 preset over data 0");
    tick(); tick();
    in_clk = 1'b0; preset = 1'b0; tick();
    sig[0] = 1'b1; preset = 1'b1; in_clk = 1'b1;
    expect_at(1, SEL_Q1, 0, "R8 clear beats preset");
    tick(); tick();
    sig[0] = 1'b0; preset = 1'b0; in_clk = 1'b0;
    expect_at(1, SEL_Q1, 0, "R8 R7 still 0");
    tick(); tick();
    sig[5] = 1'b1; in_clk = 1'b1;
    expect_at(1, SEL_Q1, 1, "R4 reload 1");
    tick(); tick();
    in_clk = 1'b0; tick();

    // R2 clearing register 2 leaves register 1
    sig[6] = 1'b1; sig[2] = 1'b1;
    expect_at(1, SEL_FB2, 1, "R5 toggle up again");
    tick(); tick();
    sig[2] = 1'b0; sig[6] = 1'b0; tick();
    sig[3] = 1'b1;
    expect_at(0, SEL_FB2, 0, "R2 term 3 clears register 2");
    expect_at(0, SEL_Q1, 1, "R2 register 1 untouched");
    tick();
    sig[3] = 1'b0; tick();

    // R11 combinatorial feedback
    cfg_fb_reg = 1'b0; sig[6] = 1'b1;
    expect_at(0, SEL_FB2, 1, "R11 feedback is sum1");
    tick();
    sig[6] = 1'b0;
    expect_at(0, SEL_FB2, 0, "R11 feedback is sum1");
    tick();

    // R10 registered pin source
    cfg_pin_reg = 1'b1; sig[7] = 1'b0;
    expect_at(0, SEL_PINOUT, 1, "R10 pin from register 1");
    tick();
    sig[0] = 1'b1;
    expect_at(0, SEL_PINOUT, 0, "R10 R7 pin follows cleared register");
    tick();
    sig[0] = 1'b0;
    expect_at(0, SEL_FB, 8'h2A, "R12 feedback literal order");
    tick();

    // R13 reset clears and suppresses a false edge
    in_clk = 1'b1; sig[5] = 1'b1;
    expect_at(1, SEL_Q1, 1, "R4 load before reset");
    tick(); tick();
    in_clk = 1'b0; tick();
    rst_n = 1'b0; in_clk = 1'b1;
    expect_at(0, SEL_Q1, 0, "R13 reset clears");
    tick(); tick();
    rst_n = 1'b1;
    expect_at(1, SEL_Q1, 0, "R13 no edge from high source");
    tick(); tick(); tick();

    if (q_due.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", q_due.size());
    end
    finish_run();
  end
endmodule